// File: doc/BRIEF.md
# Reference-Domain Phase Error Detector for a Digital PLL

This block produces one signed fixed-point phase error word per reference clock cycle for an all-digital frequency synthesizer. It combines three quantities, all aligned to the reference clock before they are summed. The first is a reference phase that grows by the frequency command word, which is the wanted DCO-to-reference frequency ratio, on every reference edge. The second is a count of DCO rising edges made in the DCO clock domain and carried into the reference domain. The third is a fractional correction taken from the time-to-digital converter's rise delay and normalised by the measured DCO period.

The frequency command word has 8 integer and 16 fractional bits. The phase error word has the same 8.16 format, read as two's complement. The downstream loop filter reads the error word together with a valid flag. There is no ready input and no back-pressure: a new word is produced on every reference cycle and stays on the output until the next reference edge. The consumer must take it in that cycle or lose it.

Top module: `adpll_phase_err`

## Requirements
- R1: While rst_n is low, phase_err is 0 and phase_err_valid is 0.
- R2: phase_err_valid goes high a few reference cycles after reset is released and then stays high. phase_err updates on every reference edge.
- R3: The reference phase adds {fcw_int, fcw_frac} (8.16 unsigned) on every reference edge, modulo 2^24. With the DCO fixed at N edges per reference cycle, phase_err changes by (FCW − N·2^16) mod 2^24 per cycle.
- R4: The DCO edge count is Gray coded in the DCO domain and passes through two reference-domain flops before conversion back to binary. Successive Gray values differ in at most one bit.
- R5: The correction is 2^16 − floor(tdc_rise·2^16 / (2·dco_half_per)), an unsigned value from 0 to 65536. A rise delay of 0 gives 65536.
- R6: When tdc_rise ≥ 2·dco_half_per, the correction is 0.
- R7: When dco_half_per is 0, the previous correction is kept. Changes on tdc_rise then have no effect on phase_err.
- R8: phase_err = ref_phase − (dco_count·2^16) + correction, taken modulo 2^24. Wrap-around of either accumulator has no effect: at lock, phase_err stays constant across wraps.
- R9: A change on tdc_rise or dco_half_per that is applied before reference edge k first shows in phase_err after edge k+2. The division itself finishes within one reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| dco_clk | input | 1 | DCO clock whose edges are counted |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fcw_int | input | 8 | Integer part of the frequency command word |
| fcw_frac | input | 16 | Fractional part of the frequency command word |
| tdc_rise | input | 8 | TDC delay from reference edge to next DCO rise, in TDC steps |
| dco_half_per | input | 8 | Half DCO period estimate, in TDC steps |
| phase_err | output | 24 | Signed 8.16 phase error |
| phase_err_valid | output | 1 | High once the phase error pipeline is filled |

## Verification
The checker verifies on every cycle the rules that hold regardless of stimulus. It checks that the Gray-coded DCO count moves by at most one bit per DCO edge, so it can cross into the reference domain safely. It checks that the correction stays in its 0 to 65536 range, that it is held while the half period is zero, that it clamps to zero when the rise delay reaches the period, and that the valid flag stays high once set. Only the directed scenarios can show the arithmetic. They cover the per-cycle drift for fractional and integer command word offsets, a constant error at lock across many accumulator wraps, the exact correction steps and their two-edge latency, and the absence of any effect from the rise delay while the period is zero.

// File: rtl/pe_pkg.sv
`timescale 1ns/1ps
package pe_pkg;
  parameter int unsigned PE_INT_W  = 8;
  parameter int unsigned PE_FRAC_W = 16;
  parameter int unsigned PE_TDC_W  = 8;
  parameter int unsigned PE_FILL   = 3;
endpackage

// File: rtl/pe_ref_acc.sv
`timescale 1ns/1ps
module pe_ref_acc #(
  parameter int unsigned PH_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] step,
  output logic [PH_W-1:0] phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + step;
  end
endmodule

// File: rtl/pe_dco_cnt.sv
`timescale 1ns/1ps
module pe_dco_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      gray  <= '0;
    end else begin
      cnt_q <= cnt_nx;
      gray  <= cnt_nx ^ (cnt_nx >> 1);
    end
  end
endmodule

// File: rtl/pe_gray_sync.sv
`timescale 1ns/1ps
module pe_gray_sync #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] bin_out
);
  logic [CNT_W-1:0] meta_q;
  logic [CNT_W-1:0] safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= gray_in;
      safe_q <= meta_q;
    end
  end

  always_comb begin
    bin_out[CNT_W-1] = safe_q[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ safe_q[i];
    end
  end
endmodule

// File: rtl/pe_frac_div.sv
`timescale 1ns/1ps
module pe_frac_div #(
  parameter int unsigned TDC_W  = 8,
  parameter int unsigned FRAC_W = 16
) (
  input  logic [TDC_W-1:0]  rise,
  input  logic [TDC_W-1:0]  half,
  output logic [FRAC_W:0]   corr,
  output logic              den_zero
);
  localparam int unsigned RW = TDC_W + 2;

  logic [RW-1:0]     den;
  logic [RW-1:0]     rem [FRAC_W];
  logic [FRAC_W-1:0] quo;
  logic              over;

  assign den      = {1'b0, half, 1'b0};
  assign den_zero = (half == '0);
  assign over     = ({2'b00, rise} >= den);
  assign rem[0]   = {2'b00, rise};

  for (genvar i = 0; i < FRAC_W; i++) begin : g_stage
    logic [RW-1:0] shl;
    assign shl = {rem[i][RW-2:0], 1'b0};
    assign quo[FRAC_W-1-i] = (shl >= den);
    if (i < FRAC_W - 1) begin : g_next
      assign rem[i+1] = (shl >= den) ? (shl - den) : shl;
    end
  end

  assign corr = over ? '0 : (((FRAC_W+1)'(1) << FRAC_W) - {1'b0, quo});
endmodule

// File: rtl/adpll_phase_err.sv
`timescale 1ns/1ps
module adpll_phase_err
  import pe_pkg::*;
#(
  parameter int unsigned INT_W  = PE_INT_W,
  parameter int unsigned FRAC_W = PE_FRAC_W,
  parameter int unsigned TDC_W  = PE_TDC_W,
  parameter int unsigned FILL   = PE_FILL
) (
  input  logic                     ref_clk,
  input  logic                     dco_clk,
  input  logic                     rst_n,
  input  logic [INT_W-1:0]         fcw_int,
  input  logic [FRAC_W-1:0]        fcw_frac,
  input  logic [TDC_W-1:0]         tdc_rise,
  input  logic [TDC_W-1:0]         dco_half_per,
  output logic [INT_W+FRAC_W-1:0]  phase_err,
  output logic                     phase_err_valid
);
  localparam int unsigned PH_W  = INT_W + FRAC_W;
  localparam int unsigned FIL_W = $clog2(FILL + 1);

  logic [PH_W-1:0]   ref_ph;
  logic [INT_W-1:0]  dco_gray;
  logic [INT_W-1:0]  var_ph;
  logic [TDC_W-1:0]  rise_q;
  logic [TDC_W-1:0]  half_q;
  logic [FRAC_W:0]   corr_nx;
  logic [FRAC_W:0]   corr_q;
  logic              den_zero;
  logic [FIL_W-1:0]  fill_q;

  pe_ref_acc #(.PH_W(PH_W)) u_ref (
    .clk(ref_clk), .rst_n(rst_n), .step({fcw_int, fcw_frac}), .phase(ref_ph)
  );

  pe_dco_cnt #(.CNT_W(INT_W)) u_cnt (
    .clk(dco_clk), .rst_n(rst_n), .gray(dco_gray)
  );

  pe_gray_sync #(.CNT_W(INT_W)) u_sync (
    .clk(ref_clk), .rst_n(rst_n), .gray_in(dco_gray), .bin_out(var_ph)
  );

  pe_frac_div #(.TDC_W(TDC_W), .FRAC_W(FRAC_W)) u_div (
    .rise(rise_q), .half(half_q), .corr(corr_nx), .den_zero(den_zero)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      half_q <= '0;
      corr_q <= (FRAC_W+1)'(1) << FRAC_W;
    end else begin
      rise_q <= tdc_rise;
      half_q <= dco_half_per;
      if (!den_zero) corr_q <= corr_nx;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_err       <= '0;
      phase_err_valid <= 1'b0;
      fill_q          <= '0;
    end else begin
      phase_err <= ref_ph - {var_ph, {FRAC_W{1'b0}}} + PH_W'(corr_q);
      if (fill_q != FIL_W'(FILL)) fill_q <= fill_q + FIL_W'(1);
      else                        phase_err_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/pe_err_checker.sv
`timescale 1ns/1ps
module pe_err_checker #(
  parameter int unsigned INT_W  = 8,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned TDC_W  = 8
) (
  input logic                    ref_clk,
  input logic                    dco_clk,
  input logic                    rst_n,
  input logic                    valid,
  input logic [INT_W+FRAC_W-1:0] err,
  input logic [INT_W-1:0]        gray,
  input logic [FRAC_W:0]         corr,
  input logic [TDC_W-1:0]        rise_q,
  input logic [TDC_W-1:0]        half_q
);
  always @(posedge ref_clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (!valid && err == '0);
    end
  end

  a_r2_valid_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
    valid |=> valid);

  a_r4_gray_step: assert property (@(posedge dco_clk) disable iff (!rst_n)
    $onehot0(gray ^ $past(gray)));

  a_r5_corr_range: assert property (@(posedge ref_clk) disable iff (!rst_n)
    corr <= ((FRAC_W+1)'(1) << FRAC_W));

  a_r6_clamp: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (half_q != '0 && {1'b0, rise_q} >= {half_q, 1'b0}) |=> corr == '0);

  a_r7_zero_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (half_q == '0) |=> $stable(corr));
endmodule

bind adpll_phase_err pe_err_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W), .TDC_W(TDC_W)) u_chk (
  .ref_clk(ref_clk), .dco_clk(dco_clk), .rst_n(rst_n),
  .valid(phase_err_valid), .err(phase_err), .gray(dco_gray),
  .corr(corr_q), .rise_q(rise_q), .half_q(half_q)
);

// File: tb/tb_adpll_phase_err.sv
`timescale 1ns/1ps
module tb_adpll_phase_err;
  logic        ref_clk = 1'b0;
  logic        dco_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic [7:0]  fcw_int = 8'd4;
  logic [15:0] fcw_frac = 16'd0;
  logic [7:0]  tdc_rise = 8'd20;
  logic [7:0]  dco_half_per = 8'd50;
  logic [23:0] phase_err;
  logic        phase_err_valid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  adpll_phase_err dut (
    .ref_clk(ref_clk), .dco_clk(dco_clk), .rst_n(rst_n),
    .fcw_int(fcw_int), .fcw_frac(fcw_frac), .tdc_rise(tdc_rise),
    .dco_half_per(dco_half_per), .phase_err(phase_err),
    .phase_err_valid(phase_err_valid)
  );

  always #2.5 ref_clk = ~ref_clk;               // 200 MHz reference
  initial begin #0.3; forever #0.625 dco_clk = ~dco_clk; end  // exactly 4 DCO edges per reference cycle

  function automatic int exp_corr(int rise, int half);
    int den = 2 * half;
    if (rise >= den) return 0;
    return 65536 - (rise * 65536) / den;
  endfunction

  task automatic check(string req, bit ok, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  // step a TDC input and check the two-edge latency and the size of the step
  task automatic step_tdc(string req, int new_rise, int new_half, int old_corr, int new_corr);
    logic [23:0] e0;
    e0 = phase_err;
    tdc_rise = 8'(new_rise);
    dco_half_per = 8'(new_half);
    tick(1);
    check("R9 no change after first edge", phase_err == e0, phase_err, e0);
    tick(1);
    check("R9 no change after second edge", phase_err == e0, phase_err, e0);
    tick(1);
    check(req, phase_err == e0 + 24'(new_corr) - 24'(old_corr), phase_err,
          e0 + 24'(new_corr) - 24'(old_corr));
  endtask

  task automatic t_reset;
    tick(2);
    check("R1 err in reset", phase_err == 24'd0, phase_err, 0);
    check("R1 valid in reset", phase_err_valid == 1'b0, phase_err_valid, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_valid;
    tick(6);
    check("R2 valid rises", phase_err_valid == 1'b1, phase_err_valid, 1);
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if (!phase_err_valid) check("R2 valid stays high", 1'b0, 0, 1);
    end
    check("R2 valid held", phase_err_valid == 1'b1, phase_err_valid, 1);
  endtask

  task automatic t_lock_wrap;
    logic [23:0] e0;
    int bad = 0;
    e0 = phase_err;
    for (int i = 0; i < 80; i++) begin  // 80 cycles pass the 2^24 wrap at least once
      tick(1);
      if (phase_err != e0) bad++;
    end
    check("R8 constant at lock across wraps", bad == 0, bad, 0);
    check("R4 count carried every cycle", phase_err == e0, phase_err, e0);
  endtask

  task automatic t_drift(string req, int fi, int ff, int delta);
    logic [23:0] prev;
    int bad = 0;
    fcw_int = 8'(fi);
    fcw_frac = 16'(ff);
    tick(4);
    prev = phase_err;
    for (int i = 0; i < 40; i++) begin
      tick(1);
      if (phase_err != prev + 24'(delta)) bad++;
      prev = phase_err;
    end
    check(req, bad == 0, bad, 0);
    fcw_int = 8'd4;
    fcw_frac = 16'd0;
    tick(4);
  endtask

  task automatic t_zero_hold;
    logic [23:0] e0;
    int bad = 0;
    dco_half_per = 8'd0;
    tick(3);
    e0 = phase_err;
    for (int i = 0; i < 6; i++) begin
      tdc_rise = 8'(10 * i + 5);
      tick(1);
      if (phase_err != e0) bad++;
    end
    check("R7 rise ignored while half period is zero", bad == 0, bad, 0);
    tdc_rise = 8'd0;
    tick(3);
    check("R7 correction held", phase_err == e0, phase_err, e0);
    step_tdc("R5 resume after zero period", 50, 50, exp_corr(0, 50), exp_corr(50, 50));
  endtask

  initial begin
    t_reset();
    t_valid();
    t_lock_wrap();
    t_drift("R3 fractional drift", 4, 16'h3000, 16'h3000);
    t_drift("R3 integer drift", 5, 0, 65536);
    t_drift("R3 negative drift", 3, 16'h8000, -32768);
    step_tdc("R5 rise 20 to 40", 40, 50, exp_corr(20, 50), exp_corr(40, 50));
    step_tdc("R6 rise above period", 120, 50, exp_corr(40, 50), 0);
    step_tdc("R6 rise equal to period", 100, 50, 0, 0);
    step_tdc("R5 rise zero gives one", 0, 50, 0, 65536);
    step_tdc("R5 period change", 30, 40, 65536, exp_corr(30, 40));
    step_tdc("R5 back to base", 0, 50, exp_corr(30, 40), 65536);
    t_zero_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge ref_clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule